// File: doc/BRIEF.md
# Second-Operand Shifter with Carry-Out

This combinational unit prepares the second operand of a 32-bit datapath in the same cycle as the arithmetic or logic operation that consumes it. In register mode it takes a register value and applies one of five shift kinds: logical left, logical right, arithmetic right, rotate right, or a one-place rotate right through the carry flag. The shift amount comes either from a 5-bit instruction field or from the low 8 bits of a second register. In immediate mode it ignores the register path. It then builds the operand from an 8-bit constant rotated right by twice a 4-bit field.

Next to the operand, the unit produces the shifter carry-out, which logical instructions use as their new carry. It also applies the flag-update rule for logical and move operations. N and Z come from the operation's result, C comes from the shifter carry and V is always kept. The adder and the condition-code evaluation belong to neighbouring blocks.

Top module: `opnd_shifter_unit`

## Requirements
- R1: Shift kind code 0 (logical left) by n: n=0 passes value and carry; 1..31 shifts in zeros with carry = value bit 32-n; n=32 gives 0 with carry = bit 0; n>32 gives 0 with carry 0.
- R2: Shift kind code 1 (logical right) by n: 1..31 shifts in zeros with carry = value bit n-1; n=32 gives 0 with carry = bit 31; n>32 gives 0 with carry 0.
- R3: Shift kind code 2 (arithmetic right) by n: 1..31 fills with the sign bit with carry = value bit n-1; n>=32 gives all bits equal to bit 31 and carry = bit 31.
- R4: Shift kind code 3 (rotate right) by nonzero n rotates by n mod 32, and carry equals bit 31 of the result.
- R5: Shift kind code 4 (rotate through carry) ignores the amount: result = {carry_in, value[31:1]}, carry = value bit 0.
- R6: An effective shift amount of 0 (codes 0 to 3) leaves the operand equal to the value and the carry equal to carry_in.
- R7: With amt_is_reg=1 the amount is all 8 bits of shift_amt; with amt_is_reg=0 only shift_amt[4:0] is used and bits 7:5 have no effect.
- R8: With imm_sel=1 the operand is imm_byte zero-extended to 32 bits and rotated right by 2*imm_rot; the register value and shift inputs have no effect.
- R9: In immediate mode the carry equals carry_in when imm_rot=0 and bit 31 of the operand otherwise.
- R10: With set_flags=1, flags_out (bit 3 N, bit 2 Z, bit 1 C, bit 0 V) = {logic_result[31], logic_result==0, shifter_carry, flags_in[0]}.
- R11: With set_flags=0, flags_out equals flags_in.
- R12: Shift kind codes 5 to 7 pass the value and carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_value | input | 32 | Register value to be shifted |
| shift_kind | input | 3 | Shift kind code (0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate through carry) |
| shift_amt | input | 8 | Shift amount |
| amt_is_reg | input | 1 | 1: amount from a register (8 bits), 0: from instruction field (5 bits) |
| carry_in | input | 1 | Current carry flag |
| imm_sel | input | 1 | Select the rotated-immediate operand |
| imm_byte | input | 8 | Immediate constant |
| imm_rot | input | 4 | Immediate rotate field (rotation = 2 x field) |
| set_flags | input | 1 | Apply the logical/move flag update |
| logic_result | input | 32 | Result of the logical or move operation |
| flags_in | input | 4 | Current N Z C V flags |
| operand | output | 32 | Second operand |
| shifter_carry | output | 1 | Shifter carry-out |
| flags_out | output | 4 | Updated N Z C V flags |

## Verification
Each shift kind, including the unused codes, is swept over amounts 0, 1, 2, 5, 31, 32, 33, 64, 200 and 255, with both carry values and both amount sources. The sweep runs on values that have a set sign bit, a clear sign bit, a mixed pattern, and all zeros. The amounts around 32 tell apart the in-range, exactly-full-width and beyond-width carry rules. Repeating each amount in 5-bit mode shows whether the upper amount bits leak through. All 4096 immediate byte and rotate pairs are compared against a bit-at-a-time model with a changing register input. Move results, zero results and both flag-enable states cover the N and Z update and the preservation of V.

// File: rtl/shop_pkg.sv
package shop_pkg;
    localparam int DATA_W    = 32;
    localparam int AMT_W     = 8;
    localparam int FIELD_W   = 5;
    localparam int IMM_W     = 8;
    localparam int ROT_W     = 4;
    localparam int KIND_W    = 3;
    localparam int FLAG_W    = 4;
    localparam int IDX_W     = $clog2(DATA_W);

    typedef enum logic [KIND_W-1:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              carry;
    } shift_res_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic logic [DATA_W-1:0] rot_right(input logic [DATA_W-1:0] x,
                                                    input logic [IDX_W-1:0] r);
        logic [2*DATA_W-1:0] dbl;
        dbl = {x, x} >> r;
        return dbl[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/opnd_barrel.sv
module opnd_barrel
    import shop_pkg::*;
(
    input  logic [DATA_W-1:0] src,
    input  shift_kind_e       kind,
    input  logic [AMT_W-1:0]  amt,
    input  logic              cin,
    output shift_res_t        res
);
    localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(DATA_W);

    logic [IDX_W-1:0] n_lo;
    assign n_lo = amt[IDX_W-1:0];

    always_comb begin
        res.data  = src;
        res.carry = cin;
        case (kind)
            SK_LSL: begin
                if (amt == '0) begin
                    res.data  = src;
                end else if (amt < AMT_FULL) begin
                    {res.carry, res.data} = {1'b0, src} << n_lo;
                end else if (amt == AMT_FULL) begin
                    res.data  = '0;
                    res.carry = src[0];
                end else begin
                    res.data  = '0;
                    res.carry = 1'b0;
                end
            end
            SK_LSR: begin
                if (amt == '0) begin
                    res.data  = src;
                end else if (amt < AMT_FULL) begin
                    {res.data, res.carry} = {src, 1'b0} >> n_lo;
                end else if (amt == AMT_FULL) begin
                    res.data  = '0;
                    res.carry = src[DATA_W-1];
                end else begin
                    res.data  = '0;
                    res.carry = 1'b0;
                end
            end
            SK_ASR: begin
                if (amt == '0) begin
                    res.data  = src;
                end else if (amt < AMT_FULL) begin
                    {res.data, res.carry} = $signed({src, 1'b0}) >>> n_lo;
                end else begin
                    res.data  = {DATA_W{src[DATA_W-1]}};
                    res.carry = src[DATA_W-1];
                end
            end
            SK_ROR: begin
                if (amt != '0) begin
                    res.data  = rot_right(src, n_lo);
                    res.carry = res.data[DATA_W-1];
                end
            end
            SK_RRX: begin
                res.data  = {cin, src[DATA_W-1:1]};
                res.carry = src[0];
            end
            default: begin
                res.data  = src;
                res.carry = cin;
            end
        endcase
    end

    logic [DATA_W-1:0] low_mask;
    assign low_mask = ~({DATA_W{1'b1}} << n_lo);

    always_comb begin
        if (kind == SK_LSL && amt != '0 && amt < AMT_FULL)
            a_r1_lsl_low_zero: assert ((res.data & low_mask) == '0)
                else $error("R1 low bits not cleared");
        if (kind == SK_ASR)
            a_r3_asr_sign_kept: assert (res.data[DATA_W-1] == src[DATA_W-1])
                else $error("R3 sign bit changed");
        if (kind == SK_ROR)
            a_r4_ror_popcount: assert ($countones(res.data) == $countones(src))
                else $error("R4 rotate lost bits");
        if (kind == SK_RRX)
            a_r5_rrx_carry_path: assert (res.data[DATA_W-1] == cin && res.carry == src[0])
                else $error("R5 carry path wrong");
        if (amt == '0 && kind != SK_RRX)
            a_r6_zero_amount: assert (res.data == src && res.carry == cin)
                else $error("R6 zero amount changed value");
    end
endmodule

// File: rtl/opnd_immrot.sv
module opnd_immrot
    import shop_pkg::*;
(
    input  logic [IMM_W-1:0] imm_byte,
    input  logic [ROT_W-1:0] imm_rot,
    input  logic             cin,
    output shift_res_t       res
);
    logic [IDX_W-1:0] rot_amt;
    assign rot_amt = IDX_W'({imm_rot, 1'b0});

    always_comb begin
        res.data  = rot_right(DATA_W'(imm_byte), rot_amt);
        res.carry = (imm_rot == '0) ? cin : res.data[DATA_W-1];
    end

    always_comb begin
        a_r8_imm_popcount: assert ($countones(res.data) == $countones(imm_byte))
            else $error("R8 immediate bits lost");
        if (imm_rot == '0)
            a_r9_imm_carry_kept: assert (res.carry == cin && res.data[DATA_W-1:IMM_W] == '0)
                else $error("R9 unrotated immediate wrong");
    end
endmodule

// File: rtl/opnd_flags.sv
module opnd_flags
    import shop_pkg::*;
(
    input  logic              set_flags,
    input  logic [DATA_W-1:0] result,
    input  logic              shc,
    input  nzcv_t             flags_in,
    output nzcv_t             flags_out
);
    always_comb begin
        flags_out = flags_in;
        if (set_flags) begin
            flags_out.n = result[DATA_W-1];
            flags_out.z = (result == '0);
            flags_out.c = shc;
        end
    end

    always_comb begin
        a_r10_v_preserved: assert (flags_out.v == flags_in.v)
            else $error("R10 overflow flag altered");
        if (!set_flags)
            a_r11_no_update: assert (flags_out == flags_in)
                else $error("R11 flags changed without enable");
    end
endmodule

// File: rtl/opnd_shifter_unit.sv
module opnd_shifter_unit
    import shop_pkg::*;
(
    input  logic [31:0] op_value,
    input  logic [2:0]  shift_kind,
    input  logic [7:0]  shift_amt,
    input  logic        amt_is_reg,
    input  logic        carry_in,
    input  logic        imm_sel,
    input  logic [7:0]  imm_byte,
    input  logic [3:0]  imm_rot,
    input  logic        set_flags,
    input  logic [31:0] logic_result,
    input  logic [3:0]  flags_in,
    output logic [31:0] operand,
    output logic        shifter_carry,
    output logic [3:0]  flags_out
);
    logic [AMT_W-1:0] amt_eff;
    shift_res_t       reg_res;
    shift_res_t       imm_res;
    shift_res_t       sel_res;
    nzcv_t            nzcv_new;

    assign amt_eff = amt_is_reg ? shift_amt : AMT_W'(shift_amt[FIELD_W-1:0]);

    opnd_barrel u_barrel (
        .src  (op_value),
        .kind (shift_kind_e'(shift_kind)),
        .amt  (amt_eff),
        .cin  (carry_in),
        .res  (reg_res)
    );

    opnd_immrot u_immrot (
        .imm_byte (imm_byte),
        .imm_rot  (imm_rot),
        .cin      (carry_in),
        .res      (imm_res)
    );

    assign sel_res       = imm_sel ? imm_res : reg_res;
    assign operand       = sel_res.data;
    assign shifter_carry = sel_res.carry;

    opnd_flags u_flags (
        .set_flags (set_flags),
        .result    (logic_result),
        .shc       (shifter_carry),
        .flags_in  (nzcv_t'(flags_in)),
        .flags_out (nzcv_new)
    );

    assign flags_out = nzcv_new;

    always_comb begin
        if (!imm_sel && shift_kind > 3'd4)
            a_r12_unused_code_pass: assert (operand == op_value && shifter_carry == carry_in)
                else $error("R12 unused code altered value");
    end
endmodule

// File: tb/opnd_shifter_unit_test.sv
module opnd_shifter_unit_test;
    logic        clk = 1'b0;
    logic [31:0] op_value = '0;
    logic [2:0]  shift_kind = '0;
    logic [7:0]  shift_amt = '0;
    logic        amt_is_reg = 1'b0;
    logic        carry_in = 1'b0;
    logic        imm_sel = 1'b0;
    logic [7:0]  imm_byte = '0;
    logic [3:0]  imm_rot = '0;
    logic        set_flags = 1'b0;
    logic [31:0] logic_result = '0;
    logic [3:0]  flags_in = '0;
    logic [31:0] operand;
    logic        shifter_carry;
    logic [3:0]  flags_out;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    opnd_shifter_unit uut (
        .op_value(op_value), .shift_kind(shift_kind), .shift_amt(shift_amt),
        .amt_is_reg(amt_is_reg), .carry_in(carry_in), .imm_sel(imm_sel),
        .imm_byte(imm_byte), .imm_rot(imm_rot), .set_flags(set_flags),
        .logic_result(logic_result), .flags_in(flags_in), .operand(operand),
        .shifter_carry(shifter_carry), .flags_out(flags_out)
    );

    // One bit per step model: returns {carry, value}
    function automatic logic [32:0] ref_shift(input logic [31:0] v, input int k,
                                              input int n, input logic c);
        logic [31:0] x;
        logic        cc;
        x  = v;
        cc = c;
        case (k)
            0: for (int i = 0; i < n; i++) begin cc = x[31]; x = {x[30:0], 1'b0}; end
            1: for (int i = 0; i < n; i++) begin cc = x[0];  x = {1'b0, x[31:1]}; end
            2: for (int i = 0; i < n; i++) begin cc = x[0];  x = {x[31], x[31:1]}; end
            3: for (int i = 0; i < n; i++) begin cc = x[0];  x = {x[0], x[31:1]}; end
            4: begin cc = x[0]; x = {c, x[31:1]}; end
            default: ;
        endcase
        return {cc, x};
    endfunction

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_flags(input logic en, input logic [31:0] res,
                               input logic shc, input logic [3:0] fin);
        logic [3:0] exp;
        exp = en ? {res[31], res == 32'd0, shc, fin[0]} : fin;
        @(negedge clk);
        check(en ? "R10 flags" : "R11 flags", {29'd0, flags_out}, {29'd0, exp});
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] vals [4];
        int          amts [10];
        logic [32:0] exp;
        int          nsel;
        string       tag;
        int          idx;
        vals[0] = 32'h8000_0001; vals[1] = 32'hF0F0_1234;
        vals[2] = 32'h7FFF_FFFE; vals[3] = 32'h0000_0000;
        amts = '{0, 1, 2, 5, 31, 32, 33, 64, 200, 255};
        idx = 0;

        // reset/idle state: all inputs zero
        @(negedge clk);
        check("R6 idle", {shifter_carry, operand}, 33'd0);
        check("R11 idle", {29'd0, flags_out}, 33'd0);

        // register-operand sweep
        for (int vi = 0; vi < 4; vi++)
            for (int k = 0; k < 8; k++)
                for (int ai = 0; ai < 10; ai++)
                    for (int c = 0; c < 2; c++)
                        for (int r = 0; r < 2; r++) begin
                            @(posedge clk);
                            op_value   = vals[vi];
                            shift_kind = 3'(k);
                            shift_amt  = 8'(amts[ai]);
                            amt_is_reg = r[0];
                            carry_in   = c[0];
                            imm_sel    = 1'b0;
                            imm_byte   = 8'hA5;
                            imm_rot    = 4'(ai);
                            nsel = r ? amts[ai] : (amts[ai] % 32);
                            exp  = ref_shift(vals[vi], k, nsel, c[0]);
                            case (k)
                                0: tag = "R1 lsl";
                                1: tag = "R2 lsr";
                                2: tag = "R3 asr";
                                3: tag = "R4 ror";
                                4: tag = "R5 rrx";
                                default: tag = "R12 unused code";
                            endcase
                            if (nsel == 0 && k < 4) tag = "R6 zero amount";
                            else if (r == 0 && amts[ai] >= 32) tag = {tag, " R7 field amount"};
                            set_flags    = idx[0];
                            flags_in     = 4'(idx);
                            logic_result = exp[31:0];
                            @(negedge clk);
                            check(tag, {shifter_carry, operand}, exp);
                            check_flags(idx[0], exp[31:0], exp[32], 4'(idx));
                            idx++;
                        end

        // immediate sweep: every byte and rotate field
        for (int b = 0; b < 256; b++)
            for (int rt = 0; rt < 16; rt++) begin
                @(posedge clk);
                imm_sel    = 1'b1;
                imm_byte   = 8'(b);
                imm_rot    = 4'(rt);
                carry_in   = b[0] ^ rt[0];
                op_value   = 32'(b * 7919 + rt);
                shift_kind = 3'(rt % 5);
                shift_amt  = 8'(b);
                amt_is_reg = rt[1];
                exp = ref_shift(32'(b), 3, 2 * rt, b[0] ^ rt[0]);
                @(negedge clk);
                check("R8 R9 immediate", {shifter_carry, operand}, exp);
            end

        // flag rule with a logical result unrelated to the operand
        @(posedge clk);
        imm_sel = 1'b0; shift_kind = 3'd1; shift_amt = 8'd4; amt_is_reg = 1'b1;
        op_value = 32'h0000_0018; carry_in = 1'b0;
        set_flags = 1'b1; flags_in = 4'b0101; logic_result = 32'h0;
        check_flags(1'b1, 32'h0, 1'b1, 4'b0101);
        @(posedge clk);
        logic_result = 32'h8000_0000; flags_in = 4'b0110;
        check_flags(1'b1, 32'h8000_0000, 1'b1, 4'b0110);
        @(posedge clk);
        set_flags = 1'b0; flags_in = 4'b1011;
        check_flags(1'b0, 32'h8000_0000, 1'b1, 4'b1011);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule